// File: doc/BRIEF.md
# Weight-Stationary INT8 Multiply-Accumulate Array

This block is a square array of multiply-accumulate cells for neural-network inference. The weights are loaded once and stay in place, while activations stream through. Each cell keeps two signed 8-bit weights, one in each of two banks. Each cycle, every cell of bank 0 multiplies its weight by the 8-bit activation of its row taken from activation stream 0. Every cell of bank 1 does the same with activation stream 1. So a cell consumes a pair of activations per cycle.

The products in a column are summed into a per-column partial sum for each bank. Each per-column, per-bank sum goes into its own signed 32-bit accumulator. Twenty accumulate cycles therefore produce a dot product of 320 elements for each column. Because the two banks are independent, one bank can be reloaded row by row while the other keeps accumulating.

A slower wide mode joins the two weight bytes of a cell into one 16-bit operand and the two activation streams into one 16-bit activation. Each cell then performs a single multiply-accumulate that occupies two cycles. Only bank 0's accumulators are used in this mode, which gives a quarter of the byte-mode throughput. The wide arithmetic is plain signed integer and does not model floating-point rounding.

Top module: `mac_supercell`

## Requirements
- R1: After reset, all 32 accumulators read zero, `res_vld_o` is 00 and `busy_o` is 0.
- R2: When `wld_i` is high at a clock edge, the weights of row `wrow_i` in bank `wbank_i` are written. Column c takes the byte `wdata_i[8c+7:8c]`, and no other weight changes. Computation in that same cycle still uses the old weights.
- R3: In byte mode (`fp16_i`=0) with `acc_en_i[b]` high, the accumulator of bank b and column c adds the sum over rows r of w[b][r][c] × act_b[r]. Both values are signed bytes, and lane r of `act0_i`/`act1_i` is bits [8r+7:8r]. The new value appears on `res_o` bits [(16b+c)*32+31 : (16b+c)*32] after that edge. The two banks are independent.
- R4: If `acc_clr_i[b]` is high together with `acc_en_i[b]` in byte mode, the accumulator is loaded with the partial sum instead of adding to it, and a new dot product starts. If `acc_clr_i[b]` is high alone, the accumulator becomes zero.
- R5: Accumulation is signed 32-bit and wraps modulo 2^32.
- R6: The accumulates of each bank are counted from the last clear or the last completed product. The 20th one raises `res_vld_o[b]` for exactly the next cycle, and the count then restarts while accumulation continues.
- R7: Loading weights into one bank leaves the other bank's accumulators and progress unchanged.
- R8: In wide mode (`fp16_i`=1), `acc_en_i[0]` with `busy_o` low issues one MAC. The activations and `acc_clr_i[0]` are captured at issue. `busy_o` is high during the following cycle. At the end of that cycle, the bank-0 accumulator adds (or, if cleared, takes) the sum over rows of {w[1][r][c],w[0][r][c]} × {act1[r],act0[r]}, both read as signed 16-bit. Controls during the busy cycle are ignored, and bank 1 does nothing.
- R9: In wide mode, the 20th completed MAC raises `res_vld_o[0]` in the following cycle.
- R10: With no enable and no clear, every accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wld_i | input | 1 | Weight row write strobe |
| wbank_i | input | 1 | Bank receiving the weight row |
| wrow_i | input | 4 | Row index for the weight write |
| wdata_i | input | 128 | Sixteen weight bytes, column c at byte c |
| act0_i | input | 128 | Activation stream for bank 0, lane r at byte r |
| act1_i | input | 128 | Activation stream for bank 1, lane r at byte r |
| acc_en_i | input | 2 | Accumulate enable per bank |
| acc_clr_i | input | 2 | Start-new-product / clear per bank |
| fp16_i | input | 1 | Wide two-cycle mode select |
| res_o | output | 1024 | 32 accumulators, bank-major then column |
| res_vld_o | output | 2 | One-cycle completion pulse per bank |
| busy_o | output | 1 | Wide MAC in its second cycle |

## Verification
The bench targets several corner cases.

- **Weight-load timing:** a load in the same cycle as an accumulate must apply the old weights. A design that forwarded the new row would give the wrong sum in that cycle.
- **Completion pulse:** accumulation gaps separate the 20 accumulates, to catch a counter that counts cycles instead of accumulates. A design that got this wrong would pulse early. An off-by-one counter would pulse one product late.
- **Wide mode:** the bench drives the enable during the busy cycle with different activations. A design that did not ignore it would double the MAC rate and fold in the wrong operands.
- **Wraparound:** saturated 16-bit operands drive the sum past 2^31, where a saturating or truncated-width adder gives a visibly different value.
- **Bank independence:** heavy reloading of one bank alongside activity in the other would expose any cross-bank disturbance.

// File: rtl/mac_supercell.sv
module mac_supercell #(
  parameter int N       = 16,
  parameter int AW      = 8,
  parameter int ACCW    = 32,
  parameter int DOT_LEN = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wld_i,
  input  logic                   wbank_i,
  input  logic [$clog2(N)-1:0]   wrow_i,
  input  logic [N*AW-1:0]        wdata_i,
  input  logic [N*AW-1:0]        act0_i,
  input  logic [N*AW-1:0]        act1_i,
  input  logic [1:0]             acc_en_i,
  input  logic [1:0]             acc_clr_i,
  input  logic                   fp16_i,
  output logic [2*N*ACCW-1:0]    res_o,
  output logic [1:0]             res_vld_o,
  output logic                   busy_o
);
  localparam int CW = $clog2(DOT_LEN + 1);
  localparam int BW = N * ACCW;

  logic signed [AW-1:0]   wt   [2][N][N];
  logic signed [ACCW-1:0] acc  [2][N];
  logic [CW-1:0]          cnt  [2];
  logic [1:0]             vld_q;
  logic                   busy_q, hclr_q;
  logic [N*AW-1:0]        h0_q, h1_q;

  logic [N*AW-1:0]        actv [2];
  logic signed [ACCW-1:0] ps8  [2][N];
  logic signed [ACCW-1:0] ps16 [N];
  logic signed [ACCW-1:0] add  [2][N];
  logic [1:0]             go, gclr, zap;
  logic [CW-1:0]          nxt  [2];

  assign actv[0] = act0_i;
  assign actv[1] = act1_i;

  always_comb begin
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < N; c++) begin
        ps8[b][c] = '0;
        for (int r = 0; r < N; r++)
          ps8[b][c] = ps8[b][c] +
            ACCW'(wt[b][r][c]) * ACCW'($signed(actv[b][r*AW +: AW]));
      end
    end
  end

  always_comb begin
    for (int c = 0; c < N; c++) begin
      ps16[c] = '0;
      for (int r = 0; r < N; r++)
        ps16[c] = ps16[c] +
          ACCW'($signed({wt[1][r][c], wt[0][r][c]})) *
          ACCW'($signed({h1_q[r*AW +: AW], h0_q[r*AW +: AW]}));
    end
  end

  always_comb begin
    go[0]   = busy_q | (~fp16_i & acc_en_i[0]);
    go[1]   = ~fp16_i & acc_en_i[1];
    gclr[0] = busy_q ? hclr_q : acc_clr_i[0];
    gclr[1] = acc_clr_i[1];
    for (int b = 0; b < 2; b++) begin
      zap[b] = ~go[b] & ~fp16_i & acc_clr_i[b];
      nxt[b] = gclr[b] ? CW'(1) : CW'(cnt[b] + 1'b1);
      for (int c = 0; c < N; c++)
        add[b][c] = (b == 0 && busy_q) ? ps16[c] : ps8[b][c];
    end
  end

  wire issue = fp16_i & acc_en_i[0] & ~busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        cnt[b] <= '0;
        for (int c = 0; c < N; c++) begin
          acc[b][c] <= '0;
          for (int r = 0; r < N; r++) wt[b][r][c] <= '0;
        end
      end
      vld_q  <= '0;
      busy_q <= 1'b0;
      hclr_q <= 1'b0;
      h0_q   <= '0;
      h1_q   <= '0;
    end else begin
      if (wld_i)
        for (int c = 0; c < N; c++)
          wt[wbank_i][wrow_i][c] <= wdata_i[c*AW +: AW];
      busy_q <= issue;
      if (issue) begin
        h0_q   <= act0_i;
        h1_q   <= act1_i;
        hclr_q <= acc_clr_i[0];
      end
      for (int b = 0; b < 2; b++) begin
        vld_q[b] <= 1'b0;
        if (go[b]) begin
          for (int c = 0; c < N; c++)
            acc[b][c] <= (gclr[b] ? '0 : acc[b][c]) + add[b][c];
          if (nxt[b] == CW'(DOT_LEN)) begin
            cnt[b]   <= '0;
            vld_q[b] <= 1'b1;
          end else begin
            cnt[b] <= nxt[b];
          end
        end else if (zap[b]) begin
          for (int c = 0; c < N; c++) acc[b][c] <= '0;
          cnt[b] <= '0;
        end
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar c = 0; c < N; c++) begin : g_col
      assign res_o[(b*N+c)*ACCW +: ACCW] = acc[b][c];
    end
  end
  assign res_vld_o = vld_q;
  assign busy_o    = busy_q;

  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> res_vld_o == 2'b00 && !busy_o);

  p_vld_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    |res_vld_o |=> (res_vld_o & $past(res_vld_o)) == 2'b00);

  p_vld_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld_o[1] |-> $past(acc_en_i[1]) && !$past(fp16_i));

  p_other_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wld_i && !wbank_i && !fp16_i && !acc_en_i[1] && !acc_clr_i[1]
      |=> $stable(res_o[BW +: BW]));

  p_clr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fp16_i && acc_clr_i[1] && !acc_en_i[1] |=> res_o[BW +: BW] == '0);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !fp16_i && acc_en_i == 2'b00 && acc_clr_i == 2'b00
      |=> $stable(res_o));

  p_fp16_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fp16_i && acc_en_i[0] && !busy_o |=> busy_o && $stable(res_o[0 +: BW]));

  p_fp16_bank1_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fp16_i |=> !res_vld_o[1] && $stable(res_o[BW +: BW]));

  p_busy_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !busy_o);
endmodule

// File: tb/test_mac_supercell.sv
`timescale 1ns/1ps
module test_mac_supercell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wld = 0, wbank = 0, fp16 = 0;
  logic [3:0] wrow = 0;
  logic [127:0] wdata = 0, act0 = 0, act1 = 0;
  logic [1:0] en = 0, clr = 0;
  logic [1023:0] res;
  logic [1:0] vld;
  logic busy;

  always #2 clk = ~clk;

  mac_supercell i_mac_supercell (
    .clk(clk), .rst_n(rst_n), .wld_i(wld), .wbank_i(wbank), .wrow_i(wrow),
    .wdata_i(wdata), .act0_i(act0), .act1_i(act1), .acc_en_i(en),
    .acc_clr_i(clr), .fp16_i(fp16), .res_o(res), .res_vld_o(vld), .busy_o(busy));

  int total = 0, fails = 0;
  int mw [2][16][16];
  int macc [2][16];
  int mcnt [2];
  bit mvld [2];
  bit mbusy = 0, mhclr = 0;
  logic [127:0] mh0 = 0, mh1 = 0;

  function automatic int sb(input logic [7:0] v);
    return int'($signed(v));
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic compare(input string tag);
    bit bad = 0;
    total++;
    for (int b = 0; b < 2 && !bad; b++) begin
      for (int c = 0; c < 16 && !bad; c++) begin
        if ($signed(res[(b*16+c)*32 +: 32]) !== macc[b][c]) begin
          bad = 1;
          $display("FAIL %s acc[%0d][%0d] actual %0d expected %0d", tag, b, c,
                   $signed(res[(b*16+c)*32 +: 32]), macc[b][c]);
        end
      end
      if (!bad && vld[b] !== mvld[b]) begin
        bad = 1;
        $display("FAIL %s vld[%0d] actual %0b expected %0b", tag, b, vld[b], mvld[b]);
      end
    end
    if (!bad && busy !== mbusy) begin
      bad = 1;
      $display("FAIL %s busy actual %0b expected %0b", tag, busy, mbusy);
    end
    if (bad) fails++;
  endtask

  task automatic tick(input string tag);
    int p8 [2][16];
    int p16 [16];
    bit go [2];
    bit gc [2];
    bit nb;
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 16; c++) begin
        p8[b][c] = 0;
        for (int r = 0; r < 16; r++)
          p8[b][c] += mw[b][r][c] * sb(b ? act1[r*8 +: 8] : act0[r*8 +: 8]);
      end
    for (int c = 0; c < 16; c++) begin
      p16[c] = 0;
      for (int r = 0; r < 16; r++)
        p16[c] += (mw[1][r][c] * 256 + (mw[0][r][c] & 255)) *
                  (sb(mh1[r*8 +: 8]) * 256 + int'(mh0[r*8 +: 8]));
    end
    go[0] = mbusy || (!fp16 && en[0]);
    gc[0] = mbusy ? mhclr : clr[0];
    go[1] = !fp16 && en[1];
    gc[1] = clr[1];
    for (int b = 0; b < 2; b++) begin
      mvld[b] = 0;
      if (go[b]) begin
        int n;
        for (int c = 0; c < 16; c++)
          macc[b][c] = (gc[b] ? 0 : macc[b][c]) + ((b == 0 && mbusy) ? p16[c] : p8[b][c]);
        n = gc[b] ? 1 : mcnt[b] + 1;
        if (n == 20) begin mcnt[b] = 0; mvld[b] = 1; end
        else mcnt[b] = n;
      end else if (!fp16 && clr[b]) begin
        for (int c = 0; c < 16; c++) macc[b][c] = 0;
        mcnt[b] = 0;
      end
    end
    nb = fp16 && en[0] && !mbusy;
    if (nb) begin mh0 = act0; mh1 = act1; mhclr = clr[0]; end
    mbusy = nb;
    if (wld)
      for (int c = 0; c < 16; c++) mw[wbank][wrow][c] = sb(wdata[c*8 +: 8]);
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic quiet();
    wld = 0; en = 0; clr = 0;
  endtask

  task automatic load_all_random(input string tag);
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 16; r++) begin
        wld = 1; wbank = b[0]; wrow = r[3:0]; wdata = rnd128();
        tick(tag);
      end
    wld = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int b = 0; b < 2; b++) begin
      mcnt[b] = 0; mvld[b] = 0;
      for (int c = 0; c < 16; c++) begin
        macc[b][c] = 0;
        for (int r = 0; r < 16; r++) mw[b][r][c] = 0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1 reset state");

    // R2: loading weights alone changes no result
    load_all_random("R2 load");
    // R2: one-hot activation reads back a row of weights
    for (int b = 0; b < 2; b++) begin
      act0 = 0; act1 = 0;
      act0[5*8 +: 8] = 8'd1; act1[11*8 +: 8] = 8'd1;
      en = 2'b11; clr = 2'b11;
      tick("R2 readback");
    end
    quiet();
    // R2: load and accumulate in one cycle uses old weights
    act0 = rnd128(); en = 2'b01; clr = 2'b01;
    wld = 1; wbank = 0; wrow = 4'd7; wdata = rnd128();
    tick("R2 old weights used");
    quiet(); tick("R2 after load");

    // R3/R4: random byte-mode traffic
    for (int i = 0; i < 80; i++) begin
      act0 = rnd128(); act1 = rnd128();
      en = 2'($urandom); clr = (($urandom % 8) == 0) ? 2'($urandom) : 2'b00;
      tick("R3 random");
    end
    quiet();

    // R4: clear alone zeroes
    clr = 2'b11; tick("R4 clear alone");
    quiet();

    // R6: 20 accumulates with gaps, pulse on the exact cycle
    act0 = rnd128(); act1 = rnd128();
    en = 2'b11; clr = 2'b11; tick("R6 start");
    clr = 0;
    for (int i = 1; i < 20; i++) begin
      en = 2'b11; act0 = rnd128(); act1 = rnd128();
      tick("R6 count");
      if (i % 5 == 0) begin en = 0; tick("R6 gap"); end
    end
    en = 0; tick("R6 pulse ends");
    // R6: count restarts without clear
    for (int i = 0; i < 21; i++) begin en = 2'b10; act1 = rnd128(); tick("R6 rollover"); end
    quiet();

    // R7: reload one bank while the other accumulates
    for (int i = 0; i < 32; i++) begin
      int lb = (i < 16) ? 1 : 0;
      wld = 1; wbank = lb[0]; wrow = 4'(i); wdata = rnd128();
      act0 = rnd128(); act1 = rnd128();
      en = lb ? 2'b01 : 2'b10; clr = 0;
      tick("R7 load other bank");
    end
    quiet();

    // R10: idle holds
    for (int i = 0; i < 4; i++) begin act0 = rnd128(); act1 = rnd128(); tick("R10 idle"); end

    // R5/R8: saturated wide operands wrap the 32-bit sum
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < 16; r++) begin
        wld = 1; wbank = b[0]; wrow = r[3:0];
        wdata = b ? {16{8'h7f}} : {16{8'hff}};
        tick("R5 load");
      end
    wld = 0;
    fp16 = 1; act0 = {16{8'hff}}; act1 = {16{8'h7f}}; en = 2'b11; clr = 2'b11;
    tick("R8 issue");
    act0 = rnd128(); act1 = rnd128(); en = 2'b11; clr = 2'b11;
    tick("R5 wrap result / R8 busy ignored");
    en = 2'b01; clr = 0; act0 = {16{8'hff}}; act1 = {16{8'h7f}};
    tick("R8 issue again");
    en = 0; tick("R5 wrap accumulated");
    quiet(); fp16 = 0;

    // R9: twenty wide MACs with the enable held high
    load_all_random("R9 load");
    fp16 = 1; en = 2'b11; clr = 2'b01;
    act0 = rnd128(); act1 = rnd128();
    tick("R9 first issue");
    for (int i = 0; i < 41; i++) begin
      clr = 0; act0 = rnd128(); act1 = rnd128(); en = {1'($urandom), 1'b1};
      tick("R9 wide run");
    end
    quiet(); tick("R9 settle");
    fp16 = 0;

    // R3/R8: random mixed-mode traffic with loads
    for (int i = 0; i < 300; i++) begin
      if ((i % 25) == 0) fp16 = 1'($urandom);
      act0 = rnd128(); act1 = rnd128();
      en = 2'($urandom); clr = (($urandom % 6) == 0) ? 2'($urandom) : 2'b00;
      wld = 1'($urandom); wbank = 1'($urandom); wrow = 4'($urandom); wdata = rnd128();
      tick("R3 mixed");
    end
    quiet(); fp16 = 0; tick("R10 final hold");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule